// File: doc/BRIEF.md
# RMII Transmit Dibit Serializer

This block turns nibble-wide transmit data into the two-bit reduced media-independent interface (RMII) transmit stream. It runs entirely from one 50 MHz reference clock at both line rates. It paces its nibble source with a one-cycle request strobe, so the source always delivers data in step with the line and no transmit elasticity buffer is needed.

The source watches `nib_req`. In a cycle where it is high, the source presents a nibble on `nib_data` and qualifies it with `nib_valid`, and the serializer takes both on the next rising edge. A request answered with `nib_valid` high starts or continues a frame. A request answered with it low ends the frame on that nibble boundary. Each nibble leaves as two dibits, bits 1:0 first and bits 3:2 second. At 100 Mb/s each dibit lasts one reference cycle. At 10 Mb/s each dibit is held for ten cycles, so a receiver may sample any cycle in each group of ten. The speed select takes effect only between frames.

Top module: `rmii_tx_serializer`

## Requirements
- R1: While `rst` is high at a rising edge, the following cycle shows `txen` = 0, `txd` = 00 and `nib_req` = 0.
- R2: At 100 Mb/s (`spd_sel` = 1), `nib_req` is a one-cycle pulse repeating every 2 reference cycles.
- R3: At 10 Mb/s (`spd_sel` = 0), `nib_req` is a one-cycle pulse repeating every 20 reference cycles.
- R4: A nibble taken with `nib_valid` = 1 is sent as `nib_data[1:0]` first and then `nib_data[3:2]`, beginning on the edge that samples it.
- R5: At 100 Mb/s each dibit is on `txd` for exactly one reference cycle while `txen` is high.
- R6: At 10 Mb/s each dibit is held stable on `txd` for exactly ten consecutive reference cycles.
- R7: Whenever `txen` is low, `txd` is 00.
- R8: `txen` changes only on the edge that samples a requested nibble. It takes the value of `nib_valid` sampled there, so it falls only on a nibble boundary after the last valid nibble.
- R9: A change of `spd_sel` while `txen` is high has no effect on the dibit or request timing of the frame in progress.
- R10: A new `spd_sel` value seen while `txen` is low suppresses `nib_req` in that cycle. It becomes the active speed on the next edge, which starts a fresh nibble period. The first request at the new speed comes in the last cycle of that period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 50 MHz reference clock |
| rst | input | 1 | Synchronous active-high reset |
| spd_sel | input | 1 | Line rate: 1 = 100 Mb/s, 0 = 10 Mb/s |
| nib_data | input | NIB_W | Nibble offered by the source |
| nib_valid | input | 1 | Offered nibble belongs to a frame |
| nib_req | output | 1 | One-cycle request; the nibble present now is taken at the next edge |
| txd | output | 2 | RMII transmit dibit |
| txen | output | 1 | RMII transmit enable |

## Verification
The serializer is driven with frames of random length and content, with long unbroken frames of fixed patterns, and with alternating one-nibble frames. The random frames test dibit order and hold time. The fixed patterns make a stuck or swapped dibit visible. The one-nibble frames put every rise and fall of `txen` on consecutive boundaries. The speed select is toggled both inside frames and in idle gaps. This separates a design that applies the new rate at once from one that waits for the frame to end. It also tests the suppressed request and the restarted period after a legal change.

// File: rtl/rmii_tx_pkg.sv
package rmii_tx_pkg;

   typedef enum logic {
      SPD_SLOW = 1'b0,
      SPD_FAST = 1'b1
   } spd_e;

   // Reference cycles per dibit for a given speed
   function automatic int unsigned cycles_per_dibit(spd_e s, int unsigned fast_div,
                                                    int unsigned slow_div);
      return (s == SPD_FAST) ? fast_div : slow_div;
   endfunction

endpackage

// File: rtl/rmii_tx_pacer.sv
module rmii_tx_pacer
   import rmii_tx_pkg::*;
#(
   parameter int unsigned FAST_DIV = 1,
   parameter int unsigned SLOW_DIV = 10,
   parameter int unsigned DIBITS   = 2
) (
   input  logic clk,
   input  logic rst,
   input  spd_e spd,
   input  logic restart,
   output logic dibit_end,
   output logic nib_end
);
   localparam int unsigned PH_W  = $clog2(SLOW_DIV);
   localparam int unsigned IDX_W = $clog2(DIBITS);
   localparam logic [PH_W-1:0]  PH_FAST = PH_W'(cycles_per_dibit(SPD_FAST, FAST_DIV, SLOW_DIV) - 1);
   localparam logic [PH_W-1:0]  PH_SLOW = PH_W'(cycles_per_dibit(SPD_SLOW, FAST_DIV, SLOW_DIV) - 1);
   localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DIBITS - 1);

   logic [PH_W-1:0]  ph;
   logic [IDX_W-1:0] idx;
   logic [PH_W-1:0]  ph_lim;

   always_comb begin
      ph_lim    = (spd == SPD_FAST) ? PH_FAST : PH_SLOW;
      dibit_end = (ph == ph_lim);
      nib_end   = dibit_end && (idx == IDX_LAST);
   end

   always_ff @(posedge clk) begin
      if (rst || restart) begin
         ph  <= '0;
         idx <= '0;
      end else if (dibit_end) begin
         ph  <= '0;
         idx <= nib_end ? '0 : idx + 1'b1;
      end else begin
         ph  <= ph + 1'b1;
      end
   end

   AST_PH_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
      restart || (ph <= ph_lim)); // R6

   AST_NIB_PULSE: assert property (@(posedge clk) disable iff (rst)
      (nib_end && !restart) |=> !nib_end); // R2

endmodule

// File: rtl/rmii_tx_dibit_shift.sv
module rmii_tx_dibit_shift #(
   parameter int unsigned NIB_W     = 4,
   parameter bit          LSB_FIRST = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic             step,
   input  logic             valid,
   input  logic [NIB_W-1:0] data,
   output logic [1:0]       txd,
   output logic             txen
);
   logic [NIB_W-1:0] sr;
   logic [NIB_W-1:0] sr_next;

   generate
      if (LSB_FIRST) begin : g_lsb
         assign txd     = sr[1:0];
         assign sr_next = sr >> 2;
      end else begin : g_msb
         assign txd     = sr[NIB_W-1 -: 2];
         assign sr_next = sr << 2;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         sr   <= '0;
         txen <= 1'b0;
      end else if (load) begin
         sr   <= valid ? data : '0;
         txen <= valid;
      end else if (step) begin
         sr   <= sr_next;
      end
   end

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
      !txen |-> (txd == 2'b00)); // R7

   AST_EN_ON_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
      (txen != $past(txen)) |-> $past(load)); // R8

endmodule

// File: rtl/rmii_tx_speed_hold.sv
module rmii_tx_speed_hold
   import rmii_tx_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  spd_e spd_in,
   input  logic txen,
   output spd_e spd_q,
   output logic chg
);
   assign chg = (spd_in != spd_q) && !txen;

   always_ff @(posedge clk) begin
      if (rst || chg) spd_q <= spd_in;
   end

   AST_SPEED_FROZEN: assert property (@(posedge clk) disable iff (rst)
      txen |=> $stable(spd_q)); // R9

endmodule

// File: rtl/rmii_tx_serializer.sv
module rmii_tx_serializer
   import rmii_tx_pkg::*;
#(
   parameter int unsigned NIB_W     = 4,
   parameter int unsigned FAST_DIV  = 1,
   parameter int unsigned SLOW_DIV  = 10,
   parameter bit          LSB_FIRST = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             spd_sel,
   input  logic [NIB_W-1:0] nib_data,
   input  logic             nib_valid,
   output logic             nib_req,
   output logic [1:0]       txd,
   output logic             txen
);
   localparam int unsigned DIBITS = NIB_W / 2;

   generate
      if ((NIB_W % 2) != 0 || NIB_W < 4) begin : g_bad_width
         $error("NIB_W must be even and at least 4");
      end
      if (FAST_DIV < 1 || SLOW_DIV <= FAST_DIV) begin : g_bad_div
         $error("need 1 <= FAST_DIV < SLOW_DIV");
      end
   endgenerate

   spd_e spd_q;
   logic chg;
   logic dibit_end;
   logic nib_end;
   logic load;
   logic step;

   rmii_tx_speed_hold u_speed (
      .clk    (clk),
      .rst    (rst),
      .spd_in (spd_e'(spd_sel)),
      .txen   (txen),
      .spd_q  (spd_q),
      .chg    (chg)
   );

   rmii_tx_pacer #(
      .FAST_DIV (FAST_DIV),
      .SLOW_DIV (SLOW_DIV),
      .DIBITS   (DIBITS)
   ) u_pacer (
      .clk       (clk),
      .rst       (rst),
      .spd       (spd_q),
      .restart   (chg),
      .dibit_end (dibit_end),
      .nib_end   (nib_end)
   );

   assign nib_req = nib_end && !chg && !rst;
   assign load    = nib_req;
   assign step    = dibit_end && !nib_end && !chg;

   rmii_tx_dibit_shift #(
      .NIB_W     (NIB_W),
      .LSB_FIRST (LSB_FIRST)
   ) u_shift (
      .clk   (clk),
      .rst   (rst),
      .load  (load),
      .step  (step),
      .valid (nib_valid),
      .data  (nib_data),
      .txd   (txd),
      .txen  (txen)
   );

   AST_REQ_AFTER_CHANGE: assert property (@(posedge clk) disable iff (rst)
      chg |=> !nib_req); // R10

endmodule

// File: tb/sim_rmii_tx_serializer.sv
module sim_rmii_tx_serializer;
   logic       clk = 1'b0;
   logic       rst;
   logic       spd_sel;
   logic [3:0] nib_data;
   logic       nib_valid;
   logic       nib_req;
   logic [1:0] txd;
   logic       txen;

   always #10 clk = ~clk;

   rmii_tx_serializer u0 (
      .clk       (clk),
      .rst       (rst),
      .spd_sel   (spd_sel),
      .nib_data  (nib_data),
      .nib_valid (nib_valid),
      .nib_req   (nib_req),
      .txd       (txd),
      .txen      (txen)
   );

   int checks = 0;
   int errors = 0;

   // reference model state
   bit       eff;
   int       pos;
   bit       exp_en;
   bit [3:0] exp_nib;
   int       cnt;
   bit       prev_req, prev_valid, prev_spd, prev_txen;
   bit [3:0] prev_data;
   bit       after_chg;
   bit       src_valid;
   bit [3:0] src_data;
   bit       tog;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic int dib_len(input bit fast);
      return fast ? 1 : 10;
   endfunction

   function automatic bit [4:0] pick(input int mode, input bit t);
      bit v;
      bit [3:0] d;
      case (mode)
         0: begin v = ($urandom % 4) != 0; d = 4'($urandom); end
         1: begin v = 1'b1; d = t ? 4'hF : 4'h9; end
         2: begin v = t; d = 4'($urandom); end
         default: begin v = 1'b0; d = 4'($urandom); end
      endcase
      return {v, d};
   endfunction

   task automatic step(input bit new_spd, input int mode);
      bit chg;
      bit pend;
      bit exp_req;
      bit [1:0] exp_txd;
      bit [4:0] nx;
      string tag;
      int d;
      @(negedge clk);
      chg = (prev_spd != eff) && !prev_txen;
      if (chg) begin
         eff = prev_spd;
         pos = 0;
         after_chg = 1'b1;
      end else begin
         pos = (pos == 2 * dib_len(eff) - 1) ? 0 : pos + 1;
         if (prev_req) begin
            exp_en  = prev_valid;
            exp_nib = prev_data;
            cnt     = 0;
            after_chg = 1'b0;
            tog = ~tog;
            nx = pick(mode, tog);
            src_valid = nx[4];
            src_data  = nx[3:0];
         end else begin
            cnt++;
         end
      end
      d = dib_len(eff);
      exp_txd = exp_en ? ((cnt < d) ? exp_nib[1:0] : exp_nib[3:2]) : 2'b00;
      if (prev_spd != eff && prev_txen) tag = "R9";
      else if (!exp_en) tag = "R7";
      else tag = eff ? "R4 R5" : "R4 R6";
      chk(txd == exp_txd, tag, txd, exp_txd);
      chk(txen == exp_en, (prev_spd != eff && prev_txen) ? "R9" : "R8", txen, exp_en);
      spd_sel   = new_spd;
      nib_valid = src_valid;
      nib_data  = src_data;
      #1;
      pend    = (spd_sel != eff) && !txen;
      exp_req = !pend && (pos == 2 * d - 1);
      if (pend || after_chg) tag = "R10";
      else tag = eff ? "R2" : "R3";
      chk(nib_req == exp_req, tag, nib_req, exp_req);
      prev_req   = nib_req;
      prev_valid = nib_valid;
      prev_data  = nib_data;
      prev_spd   = spd_sel;
      prev_txen  = txen;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      bit cur_spd;
      void'($urandom(32'd20231));
      rst = 1'b1; spd_sel = 1'b1; nib_valid = 1'b0; nib_data = 4'h0;
      repeat (2) @(negedge clk);
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         chk(txen == 1'b0, "R1", txen, 0);
         chk(txd == 2'b00, "R1", txd, 0);
         chk(nib_req == 1'b0, "R1", nib_req, 0);
      end
      rst = 1'b0;
      eff = 1'b1; pos = 0; exp_en = 1'b0; exp_nib = 4'h0; cnt = 0;
      after_chg = 1'b0; tog = 1'b0;
      src_valid = 1'b1; src_data = 4'hB;
      nib_valid = src_valid; nib_data = src_data;
      #1;
      prev_req = nib_req; prev_valid = nib_valid; prev_data = nib_data;
      prev_spd = spd_sel; prev_txen = txen;

      // 100 Mb/s random frames
      for (int i = 0; i < 300; i++) step(1'b1, 0);
      // switch to 10 Mb/s, pending until the running frame ends
      for (int i = 0; i < 1500; i++) step(1'b0, 0);
      // long unbroken 10 Mb/s frame, then a speed flip inside it
      for (int i = 0; i < 400; i++) step(1'b0, 1);
      for (int i = 0; i < 200; i++) step(1'b1, 1);
      // let the frame end so the change is applied
      for (int i = 0; i < 100; i++) step(1'b1, 3);
      // one-nibble frames at 100 Mb/s
      for (int i = 0; i < 300; i++) step(1'b1, 2);
      // random speed flips over random traffic
      cur_spd = 1'b1;
      for (int i = 0; i < 3000; i++) begin
         if (($urandom % 60) == 0) cur_spd = ~cur_spd;
         step(cur_spd, (i % 500 < 250) ? 0 : 2);
      end
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule